// File: doc/BRIEF.md
# Dual-Slope PWM Timer

This block is an 8-bit up/down timer that drives one pulse-width output whose pulses stay centred on the counter's lowest point. A divider turns the system clock into a counting tick. It offers seven division ratios and a stop setting. The counter climbs from 0x00 to 0xFF and falls back to 0x00, so one output period takes 510 ticks. A compare threshold decides where the output changes level: it goes low where the rising count meets the threshold and goes high where the falling count meets it. An invert pin reverses every level.

Software writes the threshold into a holding register. The counter copies it into the working register only at the top of the ramp, so a period never mixes two thresholds. At the top the output always takes the level a rising-count match would give. This keeps both halves of the pulse the same length when the threshold moves off 0xFF or when a write to the counter jumps over the threshold. A threshold of 0x00 or 0xFF gives a constant level. Two sticky flags record compare matches and arrivals at the bottom. Each flag clears when a one is written to its bit. All pins are plain control and status signals. There is no streaming interface, so no back-pressure rules apply.

Top module: `pwmt_top`

## Requirements
- R1: `clk_sel` codes 1..7 advance the counter once every N clock cycles, with N = 1, 8, 32, 64, 128, 256 and 1024 in that order. Code 0 holds the count. After a reset with code 0, the first step comes N+1 cycles after a non-zero code is applied.
- R2: Any change of `clk_sel` clears the divider. After a switch to a non-zero code, the next step comes exactly N+1 cycles later, whatever the divider held before.
- R3: The count moves by exactly one per tick. It rises from 0x00 to 0xFF and then falls to 0x00, so successive visits to 0x00 are 510 ticks apart.
- R4: A threshold write goes only to the holding register. The working threshold takes the held value on the tick at which the count reaches 0xFF. Both registers are 0x00 after reset.
- R5: With the invert pin low and a working threshold k in 1..254, the output is high while the count is below k on the rising slope. It is high while the count is at or below k on the falling slope. Otherwise it is low.
- R6: With the invert pin low, a working threshold of 0x00 holds the output low and a threshold of 0xFF holds it high.
- R7: When the count reaches 0xFF, the output (invert low) goes low unless the threshold is 0xFF. This happens even without a compare match, for example when the threshold leaves 0xFF or when a counter write skips past k.
- R8: With the invert pin high, `pwm_out` is the complement of the level given by R5 to R7.
- R9: `ovf_flag` is set on the tick at which the count becomes 0x00. `cmp_flag` is set on the tick at which the count becomes equal to the working threshold. Writing 1 to `flag_clr` bit 0 clears `cmp_flag` and bit 1 clears `ovf_flag`. A set in the same cycle wins over a clear.
- R10: A counter write loads `cnt_wdata` on that cycle and suppresses counting. The next tick then steps normally but neither sets `cmp_flag` nor changes the output through a match.
- R11: Reset leaves the count at 0x00 and rising, both flags clear, and the un-inverted level low, so `pwm_out` equals `invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 3 | Divider code: 0 stop, 1..7 ratio 1..1024 |
| cmp_wdata | input | 8 | Threshold value to hold |
| cmp_we | input | 1 | Strobe that writes the holding register |
| invert | input | 1 | Inverts the output level |
| cnt_wdata | input | 8 | Value loaded into the counter |
| cnt_we | input | 1 | Strobe that writes the counter |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 compare flag, bit 1 overflow flag |
| pwm_out | output | 1 | PWM waveform |
| cmp_flag | output | 1 | Sticky compare-match flag |
| ovf_flag | output | 1 | Sticky bottom-reached flag |
| count | output | 8 | Current counter value |

## Verification
On every cycle the assertions check the following: a tick moves the count by one, an idle cycle leaves it unchanged, and a write loads the written value. They also check that the divider gives no tick in the cycle after a code change, that the extreme thresholds hold their constant level, and that the working threshold changes only at the top. At the level of the pins they check that the un-inverted output is low when the count is 0xFF and the threshold is not 0xFF, and that arriving at 0x00 raises the overflow flag. Only the bench scenarios show the complete waveform against the threshold sweep in both polarities, the exact step intervals and divider restarts, the buffering delay, the blocked match after a counter write, and the behaviour of flag clearing.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int SEL_W = 3;
  localparam int DIV_W = 10;
  localparam int FLG_CMP = 0;
  localparam int FLG_OVF = 1;

  typedef enum logic { DIR_UP = 1'b0, DIR_DOWN = 1'b1 } dir_e;

  // terminal divider value for each select code (ratio minus one)
  function automatic logic [DIV_W-1:0] tick_limit(input logic [SEL_W-1:0] code);
    case (code)
      3'd1:    tick_limit = DIV_W'(0);
      3'd2:    tick_limit = DIV_W'(7);
      3'd3:    tick_limit = DIV_W'(31);
      3'd4:    tick_limit = DIV_W'(63);
      3'd5:    tick_limit = DIV_W'(127);
      3'd6:    tick_limit = DIV_W'(255);
      3'd7:    tick_limit = DIV_W'(1023);
      default: tick_limit = '0;
    endcase
  endfunction
endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale
  import pwmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [SEL_W-1:0] sel_q;
  logic [DIV_W-1:0] div_q;
  logic             running;

  // a code change holds the divider at zero for one cycle
  assign running = (sel != '0) && (sel == sel_q);
  assign tick    = running && (div_q == tick_limit(sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      div_q <= '0;
    end else begin
      sel_q <= sel;
      if (!running || tick) div_q <= '0;
      else                  div_q <= div_q + 1'b1;
    end
  end

  // R2: no tick in the cycle in which the code differs from the previous one
  a_r2_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    (sel != $past(sel)) |-> !tick);
endmodule

// File: rtl/pwmt_count.sv
module pwmt_count
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] count_next,
  output logic         going_up,
  output logic         top_hit,
  output logic         bottom_hit,
  output logic         cmp_ok
);
  localparam logic [W-1:0] TOPV = '1;

  logic [W-1:0] count_q;
  dir_e         dir_q;
  logic         blk_q;
  logic         step;

  assign step       = tick && !wr;
  assign going_up   = (count_q == '0) ? 1'b1 :
                      (count_q == TOPV) ? 1'b0 : (dir_q == DIR_UP);
  assign count_next = going_up ? count_q + 1'b1 : count_q - 1'b1;
  assign top_hit    = step && going_up && (count_next == TOPV);
  assign bottom_hit = step && (count_next == '0);
  assign cmp_ok     = step && !blk_q;
  assign count      = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      dir_q   <= DIR_UP;
      blk_q   <= 1'b0;
    end else if (wr) begin
      count_q <= wdata;
      blk_q   <= 1'b1;
    end else if (tick) begin
      count_q <= count_next;
      dir_q   <= going_up ? DIR_UP : DIR_DOWN;
      blk_q   <= 1'b0;
    end
  end

  // R3: every step moves the count by exactly one
  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    step |=> (count_q == $past(count_q) + 1'b1) || (count_q == $past(count_q) - 1'b1));
  // R1: without tick or write the count holds
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(count_q));
  // R10: a write loads the written value
  a_r10_write_load: assert property (@(posedge clk) disable iff (rst)
    wr |=> (count_q == $past(wdata)));
endmodule

// File: rtl/pwmt_wave.sv
module pwmt_wave
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  input  logic         invert,
  input  logic         top_hit,
  input  logic         cmp_ok,
  input  logic         going_up,
  input  logic [W-1:0] count_next,
  output logic         match,
  output logic [W-1:0] ocr_active,
  output logic         pwm
);
  localparam logic [W-1:0] TOPV = '1;

  logic [W-1:0] buf_q;
  logic [W-1:0] ocr_q;
  logic [W-1:0] ocr_eff;
  logic         lvl_q;

  assign ocr_eff    = top_hit ? buf_q : ocr_q;
  assign match      = cmp_ok && (count_next == ocr_eff);
  assign ocr_active = ocr_q;
  assign pwm        = lvl_q ^ invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      ocr_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      if (cmp_we)  buf_q <= cmp_wdata;
      if (top_hit) ocr_q <= buf_q;
      // the top always takes the rising-match level, keeping pulses centred
      if (top_hit)    lvl_q <= (ocr_eff == TOPV);
      else if (match) lvl_q <= going_up ? 1'b0 : (ocr_eff != '0);
    end
  end

  // R6: zero threshold keeps the level low, full threshold keeps it high
  a_r6_zero_low: assert property (@(posedge clk) disable iff (rst)
    ((ocr_eff == '0) && !lvl_q) |=> !lvl_q);
  a_r6_full_high: assert property (@(posedge clk) disable iff (rst)
    ((ocr_eff == TOPV) && lvl_q) |=> lvl_q);
  // R4: the working threshold changes only at the top
  a_r4_load_at_top: assert property (@(posedge clk) disable iff (rst)
    !top_hit |=> $stable(ocr_q));
endmodule

// File: rtl/pwmt_flags.sv
module pwmt_flags (
  input  logic clk,
  input  logic rst,
  input  logic set_cmp,
  input  logic set_ovf,
  input  logic clr_cmp,
  input  logic clr_ovf,
  output logic cmp_flag,
  output logic ovf_flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      cmp_flag <= set_cmp || (cmp_flag && !clr_cmp);
      ovf_flag <= set_ovf || (ovf_flag && !clr_ovf);
    end
  end

  // R9: a set event always leaves its flag raised
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_cmp || set_ovf) |=> ((!$past(set_cmp) || cmp_flag) && (!$past(set_ovf) || ovf_flag)));
endmodule

// File: rtl/pwmt_top.sv
module pwmt_top
  import pwmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [W-1:0]     cmp_wdata,
  input  logic             cmp_we,
  input  logic             invert,
  input  logic [W-1:0]     cnt_wdata,
  input  logic             cnt_we,
  input  logic [1:0]       flag_clr,
  output logic             pwm_out,
  output logic             cmp_flag,
  output logic             ovf_flag,
  output logic [W-1:0]     count
);
  localparam logic [W-1:0] TOPV = '1;

  logic         tick;
  logic [W-1:0] count_next;
  logic         going_up;
  logic         top_hit;
  logic         bottom_hit;
  logic         cmp_ok;
  logic         match;
  logic [W-1:0] ocr_active;

  pwmt_prescale u_ps (
    .clk (clk),
    .rst (rst),
    .sel (clk_sel),
    .tick(tick)
  );

  pwmt_count #(.W(W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wr        (cnt_we),
    .wdata     (cnt_wdata),
    .count     (count),
    .count_next(count_next),
    .going_up  (going_up),
    .top_hit   (top_hit),
    .bottom_hit(bottom_hit),
    .cmp_ok    (cmp_ok)
  );

  pwmt_wave #(.W(W)) u_wave (
    .clk       (clk),
    .rst       (rst),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .invert    (invert),
    .top_hit   (top_hit),
    .cmp_ok    (cmp_ok),
    .going_up  (going_up),
    .count_next(count_next),
    .match     (match),
    .ocr_active(ocr_active),
    .pwm       (pwm_out)
  );

  pwmt_flags u_flg (
    .clk     (clk),
    .rst     (rst),
    .set_cmp (match),
    .set_ovf (bottom_hit),
    .clr_cmp (flag_clr[FLG_CMP]),
    .clr_ovf (flag_clr[FLG_OVF]),
    .cmp_flag(cmp_flag),
    .ovf_flag(ovf_flag)
  );

  // R7: arriving at the top by counting gives the low (un-inverted) level
  a_r7_top_level: assert property (@(posedge clk) disable iff (rst)
    ((count == TOPV) && ($past(count) == TOPV - 1'b1) && !$past(cnt_we) && (ocr_active != TOPV))
      |-> (pwm_out == invert));
  // R9: counting down onto zero raises the overflow flag
  a_r9_ovf_at_bottom: assert property (@(posedge clk) disable iff (rst)
    ((count == '0) && ($past(count) == W'(1)) && !$past(cnt_we)) |-> ovf_flag);
endmodule

// File: tb/sim_pwmt_top.sv
module sim_pwmt_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] clk_sel = '0;
  logic [7:0] cmp_wdata = '0;
  logic       cmp_we = 1'b0;
  logic       invert = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic       cnt_we = 1'b0;
  logic [1:0] flag_clr = '0;
  logic       pwm_out, cmp_flag, ovf_flag;
  logic [7:0] count;

  int n_chk = 0;
  int n_fail = 0;

  pwmt_top u0 (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .cmp_wdata(cmp_wdata), .cmp_we(cmp_we),
    .invert(invert), .cnt_wdata(cnt_wdata), .cnt_we(cnt_we), .flag_clr(flag_clr),
    .pwm_out(pwm_out), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag), .count(count)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit inv);
    rst = 1'b1; clk_sel = '0; cmp_we = 1'b0; cnt_we = 1'b0; flag_clr = '0; invert = inv;
    @(negedge clk);
    chk(count == 8'd0, "R11 count", int'(count), 0);
    chk(!cmp_flag && !ovf_flag, "R11 flags", int'({cmp_flag, ovf_flag}), 0);
    chk(pwm_out == inv, "R11 pwm", int'(pwm_out), int'(inv));
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_cmp(input int v);
    cmp_wdata = 8'(v); cmp_we = 1'b1;
    @(negedge clk);
    cmp_we = 1'b0;
  endtask

  task automatic wait_count(input int target);
    int n = 0;
    @(negedge clk);
    while (int'(count) != target && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 3000, "R3 reach count", int'(count), target);
  endtask

  // full waveform sweep at ratio 1 for one threshold and polarity
  task automatic run_k(input int k, input bit inv);
    int prev = -1;
    bit seen = 0;
    int z1 = -1;
    do_reset(inv);
    wr_cmp(k);
    clk_sel = 3'd1;
    for (int i = 0; i < 1045; i++) begin
      int c;
      int base;
      bit down;
      int expv;
      @(negedge clk);
      c = int'(count);
      base = int'(pwm_out ^ inv);
      if (c == 255) seen = 1;
      if (!seen && c == 127) chk(base == 0, "R4 held value not yet active", base, 0);
      if (seen) begin
        down = (prev >= 0) && (c < prev);
        if (k == 255) expv = 1;
        else if (k == 0) expv = 0;
        else expv = down ? int'(c <= k) : int'(c < k);
        chk(base == expv,
            inv ? "R8 inverted level" : (c == 255 ? "R7 top level" :
            ((k == 0 || k == 255) ? "R6 constant level" : "R5 level")), base, expv);
        if (prev >= 0) chk(c == prev + 1 || c == prev - 1, "R3 unit step", c, prev);
        if (c == 0) begin
          if (z1 >= 0) chk(i - z1 == 510, "R3 period", i - z1, 510);
          z1 = i;
        end
      end
      prev = c;
    end
  endtask

  task automatic ps_test(input int sel, input int n);
    int first = -1;
    int second = -1;
    int prev = 0;
    do_reset(0);
    clk_sel = 3'(sel);
    for (int i = 1; i <= 2*n + 3; i++) begin
      @(negedge clk);
      if (int'(count) != prev) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
        prev = int'(count);
      end
    end
    chk(first == n + 1, "R1 first step", first, n + 1);
    chk(second - first == n, "R1 step interval", second - first, n);
  endtask

  initial begin
    int c0;
    int idx;
    // R5 R6 R7 R8 sweep
    for (int inv = 0; inv < 2; inv++) begin
      run_k(0, inv[0]);   run_k(1, inv[0]);   run_k(2, inv[0]);
      run_k(127, inv[0]); run_k(128, inv[0]); run_k(254, inv[0]);
      run_k(255, inv[0]);
    end

    // R1 ratios
    ps_test(1, 1);   ps_test(2, 8);   ps_test(3, 32);  ps_test(4, 64);
    ps_test(5, 128); ps_test(6, 256); ps_test(7, 1024);

    // R2 divider restart on code change
    do_reset(0);
    clk_sel = 3'd7;
    repeat (300) @(negedge clk);
    c0 = int'(count);
    clk_sel = 3'd2;
    idx = -1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (idx < 0 && int'(count) != c0) idx = i;
    end
    chk(idx == 9, "R2 restart delay", idx, 9);

    // R1 stop code
    clk_sel = 3'd1;
    repeat (20) @(negedge clk);
    clk_sel = 3'd0;
    c0 = int'(count);
    repeat (40) @(negedge clk);
    chk(int'(count) == c0, "R1 stop holds", int'(count), c0);

    // R9 flags and R10 counter write
    do_reset(0);
    wr_cmp(100);
    clk_sel = 3'd1;
    wait_count(255);
    wait_count(101);
    chk(cmp_flag == 1'b0, "R9 cmp flag before match", int'(cmp_flag), 0);
    @(negedge clk);
    chk(cmp_flag == 1'b1, "R9 cmp flag on match", int'(cmp_flag), 1);
    flag_clr = 2'b01;
    @(negedge clk);
    flag_clr = 2'b00;
    chk(cmp_flag == 1'b0, "R9 cmp flag cleared", int'(cmp_flag), 0);
    wait_count(0);
    chk(ovf_flag == 1'b1, "R9 ovf flag at bottom", int'(ovf_flag), 1);
    flag_clr = 2'b10;
    @(negedge clk);
    flag_clr = 2'b00;
    chk(ovf_flag == 1'b0, "R9 ovf flag cleared", int'(ovf_flag), 0);
    wait_count(50);
    cnt_wdata = 8'd99; cnt_we = 1'b1;
    @(negedge clk);
    cnt_we = 1'b0;
    chk(count == 8'd99, "R10 write wins", int'(count), 99);
    @(negedge clk);
    chk(count == 8'd100, "R10 steps after write", int'(count), 100);
    chk(cmp_flag == 1'b0, "R10 match blocked flag", int'(cmp_flag), 0);
    chk(pwm_out == 1'b1, "R10 match blocked level", int'(pwm_out), 1);
    wait_count(254);
    chk(pwm_out == 1'b1, "R10 level kept", int'(pwm_out), 1);
    @(negedge clk);
    chk(pwm_out == 1'b0, "R7 drop at top without match", int'(pwm_out), 0);
    wait_count(100);
    chk(cmp_flag == 1'b1 && pwm_out == 1'b1, "R10 next match normal",
        int'({cmp_flag, pwm_out}), 3);

    // R4 and R7: threshold leaves 0xFF
    do_reset(0);
    wr_cmp(255);
    clk_sel = 3'd1;
    wait_count(255);
    chk(pwm_out == 1'b1, "R6 full threshold high", int'(pwm_out), 1);
    wr_cmp(100);
    wait_count(150);
    chk(pwm_out == 1'b1, "R4 new value waits for top", int'(pwm_out), 1);
    wait_count(254);
    chk(pwm_out == 1'b1, "R7 high before top", int'(pwm_out), 1);
    @(negedge clk);
    chk(count == 8'd255 && pwm_out == 1'b0, "R7 transition without match",
        int'({count, pwm_out}), 510);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule